// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte Lanes

This block is a synthesizable behavioural model of a synchronous static RAM that serves as the data store of a cache. Each word is 32 bits wide and is split into four 8-bit lanes. A parameter sets the address width, so a simulation can use a small array and a product build can use the full depth. With the address width set to 17, the array holds 128K words. Every input is captured on the rising clock edge except two: output enable and the burst-order select. Those two act combinationally.

A host starts a burst by pulling either of two address strobes low. This loads the external address and clears a 2-bit burst counter. After that, each cycle with the advance input low steps the counter. The counter forms the two low address bits. With the order select low it counts in wrapping increment order, and with the order select high it counts in XOR (interleaved) order. The upper address bits never change during a burst. A write commits at the clock edge that samples it, and it goes to the address in force for that cycle. Reads are flow-through: once an edge has settled the address, the word appears combinationally with no output register in the path.

Top module: `sync_burst_sram`

## Requirements
- R1: The array holds 2^ADDR_W distinct 32-bit words. The lowest address and the highest address store independent values.
- R2: When `strobe_a_n` or `strobe_b_n` is low at a rising edge, the address register takes `addr` and the burst count becomes 0.
- R3: A load takes priority over advance. With both strobes low and `step_n` low, the new address is used unchanged, and the next advance gives count 1.
- R4: The burst count steps only at an edge where `step_n` is low and neither strobe is low. Address bits ADDR_W-1:2 stay fixed during a burst, and the count wraps from 3 to 0.
- R5: With `seq_interleave` = 0, the low address bits are (start + count) mod 4, where start is addr[1:0] at the load.
- R6: With `seq_interleave` = 1, the low address bits are start XOR count.
- R7: With `wr_en_n` low, each lane i whose `byte_we_n[i]` is low is written. Lane 0 is bits 7:0, lane 1 is 15:8, lane 2 is 23:16 and lane 3 is 31:24. The other lanes keep their contents.
- R8: All four lanes are written when `all_wr_n` is low, whatever `byte_we_n` and `wr_en_n` are. All four lanes are also written when `wr_en_n` is low together with all four `byte_we_n` bits.
- R9: With `wr_en_n` and `all_wr_n` both high, `byte_we_n` and `din` have no effect on the stored data.
- R10: A write commits at its edge, at the address of that cycle. From the next cycle on, a read at that address returns the new data with no extra latency.
- R11: `rd_valid` is 1 only while `out_en_n` is low and the previous edge performed no write. While `rd_valid` is 0, `rd_data` is 0. `out_en_n` acts without a clock.
- R12: While reset is asserted, `rd_valid` is 0. After reset the address register and the count are zero, so the first read returns word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| addr | input | ADDR_W | External word address, taken on a strobe |
| din | input | 32 | Write data |
| strobe_a_n | input | 1 | Address strobe, first source, active low |
| strobe_b_n | input | 1 | Address strobe, second source, active low |
| step_n | input | 1 | Burst advance, active low |
| seq_interleave | input | 1 | Burst order: 0 increment, 1 XOR |
| wr_en_n | input | 1 | Write enable qualifying the lane selects, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_we_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| rd_data | output | 32 | Flow-through read data, zero when not driven |
| rd_valid | output | 1 | High when rd_data is being driven |

## Verification
The bound checker watches five things on every cycle. It checks that a strobe loads the address and that an idle cycle holds it. It checks that an increment-order advance adds one to the low bits while the upper bits stay put. It checks that a global write can be read back on the very next cycle, and that the output is never driven right after a write or while output enable is high. The bench scenarios cover what needs a model of stored contents. That means XOR-order bursts from every start offset and partial lane merges. It also means writes that are ignored, the pattern seen during reset, the word read right after reset, and the independence of the highest and lowest words.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Low address bits for a burst position: increment or XOR order.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/sbs_rst_sync.sv
`timescale 1ns/1ps
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic              step_n,
  input  logic              seq_interleave,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  import sbs_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q, base_d;
  logic [1:0]      start_q, start_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            load, adv, upd_en;

  assign load   = ~strobe_a_n | ~strobe_b_n;
  assign adv    = ~step_n & ~load;
  assign upd_en = load | adv;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (load) begin
      base_d  = addr[ADDR_W-1:2];
      start_d = addr[1:0];
      cnt_d   = 2'd0;
    end else if (adv) begin
      cnt_d   = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
    end else if (upd_en) begin
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  assign eff_addr = {base_d, burst_low(start_d, cnt_d, seq_interleave)};
  assign cur_addr = {base_q, burst_low(start_q, cnt_q, seq_interleave)};
endmodule

// File: rtl/sbs_wr_decode.sv
`timescale 1ns/1ps
module sbs_wr_decode (
  input  logic              wr_en_n,
  input  logic              all_wr_n,
  input  logic [3:0]        byte_we_n,
  output sbs_pkg::lane_mask_t lane_we
);
  import sbs_pkg::*;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = ~all_wr_n | (~wr_en_n & ~byte_we_n[i]);
  end
endmodule

// File: rtl/sbs_core.sv
`timescale 1ns/1ps
module sbs_core #(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  sbs_pkg::lane_mask_t lane_we,
  input  logic [ADDR_W-1:0]   waddr,
  input  sbs_pkg::word_t      wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output sbs_pkg::word_t      rdata
);
  import sbs_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       din,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic              step_n,
  input  logic              seq_interleave,
  input  logic              wr_en_n,
  input  logic              all_wr_n,
  input  logic [3:0]        byte_we_n,
  input  logic              out_en_n,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  import sbs_pkg::*;

  logic              rst_int_n;
  logic [ADDR_W-1:0] eff_addr, cur_addr;
  lane_mask_t        lane_raw, lane_we;
  word_t             core_rdata;
  logic              wr_cyc_q, wr_cyc_d;

  sbs_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .strobe_a_n     (strobe_a_n),
    .strobe_b_n     (strobe_b_n),
    .step_n         (step_n),
    .seq_interleave (seq_interleave),
    .addr           (addr),
    .eff_addr       (eff_addr),
    .cur_addr       (cur_addr)
  );

  sbs_wr_decode u_dec (
    .wr_en_n   (wr_en_n),
    .all_wr_n  (all_wr_n),
    .byte_we_n (byte_we_n),
    .lane_we   (lane_raw)
  );

  assign lane_we = lane_raw & {LANES{rst_int_n}};

  sbs_core #(.ADDR_W(ADDR_W)) u_core (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (eff_addr),
    .wdata   (din),
    .raddr   (cur_addr),
    .rdata   (core_rdata)
  );

  assign wr_cyc_d = |lane_we;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wr_cyc_q <= 1'b0;
    else            wr_cyc_q <= wr_cyc_d;
  end

  assign rd_valid = rst_int_n & ~out_en_n & ~wr_cyc_q;
  assign rd_data  = rd_valid ? core_rdata : '0;
endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       din,
  input logic              strobe_a_n,
  input logic              strobe_b_n,
  input logic              step_n,
  input logic              seq_interleave,
  input logic              all_wr_n,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [31:0]       core_rdata,
  input logic              rd_valid
);
  // R2: a strobe loads the external address
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_a_n || !strobe_b_n) |=> cur_addr == $past(addr));

  // R4: no strobe and no advance keeps the address (order select unchanged)
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a_n && strobe_b_n && step_n) |=>
      (seq_interleave != $past(seq_interleave) || cur_addr == $past(cur_addr)));

  // R4: upper bits never move within a burst
  p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a_n && strobe_b_n) |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  // R5: increment-order advance adds one to the low bits
  p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a_n && strobe_b_n && !step_n && !seq_interleave) |=>
      (seq_interleave || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  // R8 / R10: a global write is readable on the next cycle
  p_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !all_wr_n |=> (seq_interleave != $past(seq_interleave) || core_rdata == $past(din)));

  // R11: no drive after a write cycle
  p_nodrive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !all_wr_n |=> !rd_valid);

  // R11: drive requires output enable
  always_comb begin
    if (rst_n) p_oe_r11: assert (!rd_valid || !out_en_n);
  end
endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .addr           (addr),
  .din            (din),
  .strobe_a_n     (strobe_a_n),
  .strobe_b_n     (strobe_b_n),
  .step_n         (step_n),
  .seq_interleave (seq_interleave),
  .all_wr_n       (all_wr_n),
  .out_en_n       (out_en_n),
  .cur_addr       (cur_addr),
  .core_rdata     (core_rdata),
  .rd_valid       (rd_valid)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   din;
  logic          strobe_a_n, strobe_b_n, step_n, seq_interleave;
  logic          wr_en_n, all_wr_n, out_en_n;
  logic [3:0]    byte_we_n;
  logic [31:0]   rd_data;
  logic          rd_valid;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n), .step_n(step_n),
    .seq_interleave(seq_interleave), .wr_en_n(wr_en_n), .all_wr_n(all_wr_n),
    .byte_we_n(byte_we_n), .out_en_n(out_en_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    logic        v;
    logic [31:0] d;
    bit          chk;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  exp_t        mon_e;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  logic [31:0]   rmem [DEPTH];
  logic [AW-3:0] r_base;
  logic [1:0]    r_start, r_cnt;
  logic          r_wcyc;

  // Driver: applies one cycle of stimulus, advances the reference, queues the expectation.
  task automatic drive(input bit r, input bit sa, input bit sb, input bit st, input bit il,
                       input bit oe, input bit we, input bit aw, input logic [3:0] be,
                       input logic [AW-1:0] a, input logic [31:0] d,
                       input bit chk, input string req);
    exp_t          e;
    logic [3:0]    lw;
    logic [AW-1:0] ea;
    @(negedge clk);
    rst_n = r; strobe_a_n = sa; strobe_b_n = sb; step_n = st; seq_interleave = il;
    out_en_n = oe; wr_en_n = we; all_wr_n = aw; byte_we_n = be; addr = a; din = d;
    if (!r) begin
      r_base = '0; r_start = 2'd0; r_cnt = 2'd0; r_wcyc = 1'b0;
      e.v = 1'b0; e.d = '0;
    end else begin
      if (!sa || !sb) begin
        r_base = a[AW-1:2]; r_start = a[1:0]; r_cnt = 2'd0;
      end else if (!st) begin
        r_cnt = r_cnt + 2'd1;
      end
      ea = {r_base, il ? (r_start ^ r_cnt) : (r_start + r_cnt)};
      for (int i = 0; i < 4; i++) lw[i] = !aw || (!we && !be[i]);
      for (int i = 0; i < 4; i++) if (lw[i]) rmem[ea][8*i +: 8] = d[8*i +: 8];
      r_wcyc = |lw;
      e.v = !oe && !r_wcyc;
      e.d = e.v ? rmem[ea] : 32'h0;
    end
    e.chk = chk; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idle(input bit chk, input bit il, input bit oe, input string req);
    drive(1, 1, 1, 1, il, oe, 1, 1, 4'hF, '0, '0, chk, req);
  endtask
  task automatic load_a(input logic [AW-1:0] a, input bit il, input string req);
    drive(1, 0, 1, 1, il, 0, 1, 1, 4'hF, a, '0, 1, req);
  endtask
  task automatic load_b(input logic [AW-1:0] a, input bit il, input string req);
    drive(1, 1, 0, 1, il, 0, 1, 1, 4'hF, a, '0, 1, req);
  endtask
  task automatic advance(input bit il, input string req);
    drive(1, 1, 1, 0, il, 0, 1, 1, 4'hF, '0, '0, 1, req);
  endtask
  task automatic gwrite(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    drive(1, 0, 1, 1, 0, 0, 1, 0, 4'hF, a, d, 1, req);
  endtask

  // Monitor: pops one expectation per edge and compares after the outputs settle.
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      mon_e = sbq.pop_front();
      if (mon_e.chk) begin
        n_chk++;
        if (rd_valid !== mon_e.v || rd_data !== mon_e.d) begin
          n_fail++;
          $display("FAIL %s: valid/data got %b/%h expected %b/%h",
                   mon_e.req, rd_valid, rd_data, mon_e.v, mon_e.d);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_a_n = 1; strobe_b_n = 1; step_n = 1; seq_interleave = 0;
    out_en_n = 1; wr_en_n = 1; all_wr_n = 1; byte_we_n = 4'hF; addr = '0; din = '0;
    // R12: no drive while reset is held, even with output enable low
    for (int i = 0; i < 3; i++) drive(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, '0, '0, 1, "R12");
    for (int i = 0; i < 3; i++) idle(0, 0, 0, "");

    // Fill low words and the top word with global writes; R11 no drive after a write
    for (int a = 0; a < 16; a++) gwrite(AW'(a), 32'h1000_0000 + a * 32'h0003_0107, "R11");
    gwrite(AW'(DEPTH - 1), 32'hCAFE_F00D, "R11");

    // R12: second reset, then first read returns word 0
    for (int i = 0; i < 2; i++) drive(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, '0, '0, 1, "R12");
    for (int i = 0; i < 3; i++) idle(0, 0, 0, "");
    idle(1, 0, 0, "R12");

    // R5 / R4: increment-order bursts from every start offset, with wrap
    for (int s = 0; s < 4; s++) begin
      load_a(AW'(4 + s), 0, "R2");
      for (int k = 0; k < 3; k++) advance(0, "R5");
      advance(0, "R4");
    end
    // R6: XOR-order bursts from every start offset via the second strobe
    for (int s = 0; s < 4; s++) begin
      load_b(AW'(8 + s), 1, "R2");
      for (int k = 0; k < 3; k++) advance(1, "R6");
    end
    // R4: no advance keeps the address
    idle(1, 1, 0, "R4");
    idle(1, 1, 0, "R4");
    // R3: both strobes plus advance loads, then counter starts from zero
    drive(1, 0, 0, 0, 0, 0, 1, 1, 4'hF, AW'(14), '0, 1, "R3");
    advance(0, "R3");

    // R7: partial lane write at word 5 (lanes 0 and 2 written)
    load_a(AW'(5), 0, "R2");
    drive(1, 1, 1, 1, 0, 0, 0, 1, 4'b1010, '0, 32'hDEAD_BEEF, 1, "R7");
    idle(1, 0, 0, "R7");
    drive(1, 1, 1, 1, 0, 0, 0, 1, 4'b0101, '0, 32'h1234_5678, 1, "R7");
    idle(1, 0, 0, "R7");
    // R8: write enable with all lane selects writes the full word
    drive(1, 1, 1, 1, 0, 0, 0, 1, 4'b0000, '0, 32'hA1B2_C3D4, 1, "R8");
    idle(1, 0, 0, "R8");
    // R9: lane selects without any enable change nothing
    drive(1, 1, 1, 1, 0, 0, 1, 1, 4'b0000, '0, 32'h0BAD_0BAD, 1, "R9");
    idle(1, 0, 0, "R9");
    // R8: global write ignores lane selects
    drive(1, 1, 1, 1, 0, 0, 1, 0, 4'hF, '0, 32'h5566_7788, 1, "R8");
    idle(1, 0, 0, "R8");
    // R11: output enable high removes drive
    idle(1, 0, 1, "R11");
    // R10: write during a burst step is readable on the next cycle
    load_a(AW'(2), 0, "R2");
    drive(1, 1, 1, 0, 0, 0, 0, 1, 4'b1100, '0, 32'h9900_7766, 1, "R10");
    idle(1, 0, 0, "R10");
    advance(0, "R10");
    // R1: top and bottom words are independent
    load_a(AW'(DEPTH - 1), 0, "R1");
    load_a(AW'(0), 0, "R1");

    idle(0, 0, 1, "");
    idle(0, 0, 1, "");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule